// File: doc/BRIEF.md
# Control Endpoint Stage Sequencer

This block follows the device side of a control transfer on endpoint zero. A decoded setup packet (its direction bit and its requested length) is loaded when `setup_valid` pulses. The sequencer then steps through a data stage toward the host (IN), a data stage from the host (OUT), or no data stage at all. Each `pkt_done` pulse reports one finished data packet and its byte count. An internal remaining-byte counter, together with the maximum packet size, decides which packet is the final one.

The machine has five named states: `CS_IDLE` (encoded 1), `CS_IN` (2), `CS_OUT` (3), `CS_IN_END` (4) and `CS_HALT` (5).

- `CS_IDLE` waits for a setup packet. It is also where a setup with no data stage rests.
- `CS_IN` streams data to the host. After the final IN packet is reported, the machine moves to `CS_IN_END`.
- `CS_IN_END` waits for one more `pkt_done`, which is the completion of that final packet, and then returns to `CS_IDLE`.
- `CS_OUT` receives data and returns to `CS_IDLE` on its final packet.
- `CS_HALT` is entered on a stall request from any state. It is left only by the next setup packet.

The transitions are named here for reference:

- setup-zero: any state to `CS_IDLE`
- setup-in: any state to `CS_IN`
- setup-out: any state to `CS_OUT`
- in-final: `CS_IN` to `CS_IN_END`
- in-complete: `CS_IN_END` to `CS_IDLE`
- out-final: `CS_OUT` to `CS_IDLE`
- stall: any state to `CS_HALT`

Besides the sequencer, the block holds a six-byte reply store. Local status answers (a two-byte status word, or a six-byte latency record) are staged there and read out by byte index.

Top module: `ctl_ep_seq`

## Requirements
- R1: After reset, `state_o` is 1 (`CS_IDLE`), and `tx_en`, `rx_en` and `halt_o` are low. All reply bytes read 0.
- R2: The state encoding is `CS_IDLE`=1, `CS_IN`=2, `CS_OUT`=3, `CS_IN_END`=4 and `CS_HALT`=5. `tx_en` is high exactly in `CS_IN`, `rx_en` exactly in `CS_OUT`, and `halt_o` exactly in `CS_HALT`.
- R3: A setup with `req_len`=0 and no stall request puts the machine in `CS_IDLE` on the next cycle.
- R4: A setup with a nonzero `req_len` and no stall request moves to `CS_IN` when `req_dir_in`=1 (the device-to-host bit of the request type). When `req_dir_in`=0 it moves to `CS_OUT`. The remaining-byte count is loaded with `req_len`.
- R5: In `CS_IN`, a `pkt_done` whose `pkt_bytes` is below `MPS` (64), or at least the remaining count, moves the machine to `CS_IN_END`. Any other `pkt_done` keeps it in `CS_IN` and lowers the remaining count by `pkt_bytes`.
- R6: `CS_IN_END` holds until a `pkt_done` arrives, then moves to `CS_IDLE`.
- R7: In `CS_OUT`, a `pkt_done` that is short or reaches the remaining count moves the machine to `CS_IDLE`. Any other `pkt_done` keeps it in `CS_OUT` and lowers the count.
- R8: `stall_req` moves the machine to `CS_HALT` on the next cycle from any state. It wins over a `setup_valid` or `pkt_done` in the same cycle.
- R9: `CS_HALT` holds until a `setup_valid` arrives without a stall request. That setup is decoded as in R3 and R4.
- R10: A setup arriving in `CS_IN`, `CS_OUT` or `CS_IN_END` abandons the current stage and is decoded afresh.
- R11: `pkt_done` has no effect in `CS_IDLE` or `CS_HALT`.
- R12: The reply store has 6 bytes. A write with `rsp_wr_idx` 0 to 5 is readable at that `rsp_rd_idx` from the next cycle on. Writes to index 6 or 7 are ignored, and reads of index 6 or 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| setup_valid | input | 1 | Setup packet decoded this cycle |
| req_dir_in | input | 1 | Setup direction, 1 = device to host |
| req_len | input | 16 | Requested data-stage length in bytes |
| pkt_done | input | 1 | One data packet finished this cycle |
| pkt_bytes | input | 7 | Byte count of the finished packet |
| stall_req | input | 1 | Request to stall the endpoint |
| rsp_wr_en | input | 1 | Reply byte write strobe |
| rsp_wr_idx | input | 3 | Reply byte write index |
| rsp_wr_data | input | 8 | Reply byte write data |
| rsp_rd_idx | input | 3 | Reply byte read index |
| rsp_rd_data | output | 8 | Reply byte at the read index |
| state_o | output | 3 | Current stage state code |
| tx_en | output | 1 | IN data stage enable |
| rx_en | output | 1 | OUT data stage enable |
| halt_o | output | 1 | Endpoint stalled |

## Verification
A stall request and a new setup can arrive in the same cycle. The bench drives both together in the halted state and in an active data stage, and expects `CS_HALT` one cycle later. It then drives a lone setup and expects the decoded stage. A setup and a `pkt_done` can also coincide; the setup must win. The bench shows this by aborting IN and OUT stages with a fresh setup, and by checking that the new direction and length take effect rather than the packet count.

// File: rtl/ctl_ep_pkg.sv
package ctl_ep_pkg;
    typedef enum logic [2:0] {
        CS_IDLE   = 3'd1,
        CS_IN     = 3'd2,
        CS_OUT    = 3'd3,
        CS_IN_END = 3'd4,
        CS_HALT   = 3'd5
    } ctl_state_e;
endpackage

// File: rtl/ctl_ep_remain.sv
module ctl_ep_remain #(
    parameter int LEN_W = 16,
    parameter int MPS   = 64,
    parameter int PKT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [LEN_W-1:0] load_len,
    input  logic             dec,
    input  logic [PKT_W-1:0] dec_bytes,
    output logic             final_pkt
);
    localparam logic [PKT_W-1:0] MPS_V = PKT_W'(MPS);

    logic [LEN_W-1:0] rem_q;
    logic [LEN_W-1:0] bytes_ext;
    logic             covers;

    assign bytes_ext = {{(LEN_W-PKT_W){1'b0}}, dec_bytes};
    assign covers    = (bytes_ext >= rem_q);
    assign final_pkt = (dec_bytes < MPS_V) || covers;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem_q <= '0;
        end else if (load) begin
            rem_q <= load_len;
        end else if (dec) begin
            rem_q <= covers ? '0 : (rem_q - bytes_ext);
        end
    end
endmodule

// File: rtl/ctl_ep_rspbuf.sv
module ctl_ep_rspbuf #(
    parameter int NBYTES = 6,
    parameter int IDX_W  = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_data,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_data
);
    logic [7:0] bytes_w [NBYTES];

    for (genvar gi = 0; gi < NBYTES; gi++) begin : g_byte
        logic [7:0] byte_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                byte_q <= '0;
            end else if (wr_en && (wr_idx == IDX_W'(gi))) begin
                byte_q <= wr_data;
            end
        end
        assign bytes_w[gi] = byte_q;
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NBYTES; i++) begin
            if (rd_idx == IDX_W'(i)) rd_data = bytes_w[i];
        end
    end
endmodule

// File: rtl/ctl_ep_seq.sv
module ctl_ep_seq
    import ctl_ep_pkg::*;
#(
    parameter int LEN_W     = 16,
    parameter int MPS       = 64,
    parameter int RSP_BYTES = 6,
    parameter int PKT_W     = $clog2(MPS + 1),
    parameter int RSP_IDX_W = $clog2(RSP_BYTES + 2)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 setup_valid,
    input  logic                 req_dir_in,
    input  logic [LEN_W-1:0]     req_len,
    input  logic                 pkt_done,
    input  logic [PKT_W-1:0]     pkt_bytes,
    input  logic                 stall_req,
    input  logic                 rsp_wr_en,
    input  logic [RSP_IDX_W-1:0] rsp_wr_idx,
    input  logic [7:0]           rsp_wr_data,
    input  logic [RSP_IDX_W-1:0] rsp_rd_idx,
    output logic [7:0]           rsp_rd_data,
    output logic [2:0]           state_o,
    output logic                 tx_en,
    output logic                 rx_en,
    output logic                 halt_o
);
    ctl_state_e state_q, state_d, setup_tgt;
    logic       cnt_load, cnt_dec, final_pkt;
    logic       in_data;

    assign in_data  = (state_q == CS_IN) || (state_q == CS_OUT);
    assign cnt_load = setup_valid && !stall_req;
    assign cnt_dec  = pkt_done && in_data && !setup_valid && !stall_req;

    ctl_ep_remain #(.LEN_W(LEN_W), .MPS(MPS), .PKT_W(PKT_W)) u_remain (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (cnt_load),
        .load_len  (req_len),
        .dec       (cnt_dec),
        .dec_bytes (pkt_bytes),
        .final_pkt (final_pkt)
    );

    ctl_ep_rspbuf #(.NBYTES(RSP_BYTES), .IDX_W(RSP_IDX_W)) u_rspbuf (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (rsp_wr_en),
        .wr_idx  (rsp_wr_idx),
        .wr_data (rsp_wr_data),
        .rd_idx  (rsp_rd_idx),
        .rd_data (rsp_rd_data)
    );

    always_comb begin
        if (req_len == '0)   setup_tgt = CS_IDLE;
        else if (req_dir_in) setup_tgt = CS_IN;
        else                 setup_tgt = CS_OUT;
    end

    always_comb begin
        state_d = state_q;
        if (stall_req) begin
            state_d = CS_HALT;
        end else if (setup_valid) begin
            state_d = setup_tgt;
        end else if (pkt_done) begin
            unique case (state_q)
                CS_IN:     if (final_pkt) state_d = CS_IN_END;
                CS_OUT:    if (final_pkt) state_d = CS_IDLE;
                CS_IN_END: state_d = CS_IDLE;
                CS_IDLE:   state_d = CS_IDLE;
                CS_HALT:   state_d = CS_HALT;
                default:   state_d = CS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CS_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_o = state_q;
        tx_en   = 1'b0;
        rx_en   = 1'b0;
        halt_o  = 1'b0;
        unique case (state_q)
            CS_IN:   tx_en  = 1'b1;
            CS_OUT:  rx_en  = 1'b1;
            CS_HALT: halt_o = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/ctl_ep_seq_chk.sv
module ctl_ep_seq_chk
    import ctl_ep_pkg::*;
#(
    parameter int LEN_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             setup_valid,
    input logic             req_dir_in,
    input logic [LEN_W-1:0] req_len,
    input logic             pkt_done,
    input logic             stall_req,
    input logic [2:0]       state_o,
    input logic             tx_en,
    input logic             rx_en,
    input logic             halt_o
);
    AST_STALL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        stall_req |=> (state_o == CS_HALT) && halt_o); // R8

    AST_SETUP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (setup_valid && !stall_req && req_len == '0) |=> state_o == CS_IDLE); // R3

    AST_SETUP_IN: assert property (@(posedge clk) disable iff (!rst_n)
        (setup_valid && !stall_req && req_len != '0 && req_dir_in) |=> tx_en); // R4

    AST_SETUP_OUT: assert property (@(posedge clk) disable iff (!rst_n)
        (setup_valid && !stall_req && req_len != '0 && !req_dir_in) |=> rx_en); // R4

    AST_IN_END_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == CS_IN_END && pkt_done && !setup_valid && !stall_req)
            |=> state_o == CS_IDLE); // R6

    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_o && !setup_valid) |=> halt_o); // R9

    AST_IDLE_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == CS_IDLE && !setup_valid && !stall_req)
            |=> state_o == CS_IDLE); // R11
endmodule

bind ctl_ep_seq ctl_ep_seq_chk #(.LEN_W(LEN_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .setup_valid (setup_valid),
    .req_dir_in  (req_dir_in),
    .req_len     (req_len),
    .pkt_done    (pkt_done),
    .stall_req   (stall_req),
    .state_o     (state_o),
    .tx_en       (tx_en),
    .rx_en       (rx_en),
    .halt_o      (halt_o)
);

// File: tb/test_ctl_ep_seq.sv
module test_ctl_ep_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        setup_valid = 1'b0, req_dir_in = 1'b0, pkt_done = 1'b0, stall_req = 1'b0;
    logic [15:0] req_len = '0;
    logic [6:0]  pkt_bytes = '0;
    logic        rsp_wr_en = 1'b0;
    logic [2:0]  rsp_wr_idx = '0, rsp_rd_idx = '0;
    logic [7:0]  rsp_wr_data = '0;
    logic [7:0]  rsp_rd_data;
    logic [2:0]  state_o;
    logic        tx_en, rx_en, halt_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    ctl_ep_seq i_ctl_ep_seq (
        .clk(clk), .rst_n(rst_n), .setup_valid(setup_valid), .req_dir_in(req_dir_in),
        .req_len(req_len), .pkt_done(pkt_done), .pkt_bytes(pkt_bytes),
        .stall_req(stall_req), .rsp_wr_en(rsp_wr_en), .rsp_wr_idx(rsp_wr_idx),
        .rsp_wr_data(rsp_wr_data), .rsp_rd_idx(rsp_rd_idx), .rsp_rd_data(rsp_rd_data),
        .state_o(state_o), .tx_en(tx_en), .rx_en(rx_en), .halt_o(halt_o)
    );

    // {setup, dir_in, len[15:0], pkt_done, bytes[6:0], stall, expected state[2:0]}
    localparam int NV = 26;
    localparam logic [29:0] VEC [NV] = '{
        {1'b1, 1'b1, 16'd0,   1'b0, 7'd0,  1'b0, 3'd1}, // R3 zero-length setup
        {1'b1, 1'b1, 16'd100, 1'b0, 7'd0,  1'b0, 3'd2}, // R4 IN stage
        {1'b0, 1'b0, 16'd0,   1'b1, 7'd64, 1'b0, 3'd2}, // R5 full packet, 36 left
        {1'b0, 1'b0, 16'd0,   1'b1, 7'd36, 1'b0, 3'd4}, // R5 short packet
        {1'b0, 1'b0, 16'd0,   1'b0, 7'd0,  1'b0, 3'd4}, // R6 holds
        {1'b0, 1'b0, 16'd0,   1'b1, 7'd0,  1'b0, 3'd1}, // R6 completion
        {1'b0, 1'b0, 16'd0,   1'b1, 7'd10, 1'b0, 3'd1}, // R11 ignored in idle
        {1'b1, 1'b0, 16'd128, 1'b0, 7'd0,  1'b0, 3'd3}, // R4 OUT stage
        {1'b0, 1'b0, 16'd0,   1'b1, 7'd64, 1'b0, 3'd3}, // R7 64 left
        {1'b0, 1'b0, 16'd0,   1'b1, 7'd64, 1'b0, 3'd1}, // R7 count reached
        {1'b1, 1'b1, 16'd128, 1'b0, 7'd0,  1'b0, 3'd2}, // R4
        {1'b0, 1'b0, 16'd0,   1'b1, 7'd64, 1'b0, 3'd2}, // R5
        {1'b0, 1'b0, 16'd0,   1'b1, 7'd64, 1'b0, 3'd4}, // R5 count reached
        {1'b0, 1'b0, 16'd0,   1'b1, 7'd0,  1'b0, 3'd1}, // R6
        {1'b1, 1'b0, 16'd50,  1'b0, 7'd0,  1'b0, 3'd3}, // R4
        {1'b0, 1'b0, 16'd0,   1'b1, 7'd20, 1'b0, 3'd1}, // R7 short packet
        {1'b1, 1'b1, 16'd200, 1'b0, 7'd0,  1'b0, 3'd2}, // R4
        {1'b0, 1'b0, 16'd0,   1'b0, 7'd0,  1'b1, 3'd5}, // R8 stall from IN
        {1'b0, 1'b0, 16'd0,   1'b1, 7'd5,  1'b0, 3'd5}, // R11 ignored in halt
        {1'b1, 1'b0, 16'd10,  1'b0, 7'd0,  1'b1, 3'd5}, // R8 stall beats setup
        {1'b1, 1'b0, 16'd10,  1'b0, 7'd0,  1'b0, 3'd3}, // R9 setup clears halt
        {1'b1, 1'b1, 16'd0,   1'b1, 7'd64, 1'b0, 3'd1}, // R10 abort OUT
        {1'b1, 1'b1, 16'd64,  1'b0, 7'd0,  1'b0, 3'd2}, // R4
        {1'b1, 1'b0, 16'd64,  1'b1, 7'd64, 1'b0, 3'd3}, // R10 abort IN
        {1'b1, 1'b1, 16'd64,  1'b1, 7'd1,  1'b1, 3'd5}, // R8 all at once
        {1'b1, 1'b0, 16'd0,   1'b0, 7'd0,  1'b0, 3'd1}  // R9 zero-length exit
    };

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset state", state_o, 1);
        check("R1 reset enables", {tx_en, rx_en, halt_o}, 0);
        rst_n = 1'b1;
        rsp_rd_idx = 3'd2;
        @(negedge clk);
        check("R1 reply byte after reset", rsp_rd_data, 0);

        for (int v = 0; v < NV; v++) begin
            {setup_valid, req_dir_in, req_len, pkt_done, pkt_bytes, stall_req} = VEC[v][29:3];
            @(negedge clk);
            if (state_o != VEC[v][2:0]) $display("  at vector %0d", v);
            check("R2 state", state_o, VEC[v][2:0]);
            check("R2 enables", {tx_en, rx_en, halt_o},
                  {VEC[v][2:0] == 3'd2, VEC[v][2:0] == 3'd3, VEC[v][2:0] == 3'd5});
        end
        {setup_valid, req_dir_in, req_len, pkt_done, pkt_bytes, stall_req} = '0;

        // R12: fill the six reply bytes, then try indices 6 and 7
        for (int i = 0; i < 8; i++) begin
            rsp_wr_en = 1'b1;
            rsp_wr_idx = 3'(i);
            rsp_wr_data = 8'(8'hA0 + i);
            @(negedge clk);
        end
        rsp_wr_en = 1'b0;
        for (int i = 0; i < 8; i++) begin
            rsp_rd_idx = 3'(i);
            #1;
            check("R12 reply byte", rsp_rd_data, (i < 6) ? (8'hA0 + i) : 0);
        end
        rsp_wr_en = 1'b1; rsp_wr_idx = 3'd1; rsp_wr_data = 8'h5C; rsp_rd_idx = 3'd1;
        #1;
        check("R12 write not yet visible", rsp_rd_data, 8'hA1);
        @(negedge clk);
        rsp_wr_en = 1'b0;
        check("R12 rewrite visible", rsp_rd_data, 8'h5C);

        // R1: reset from an active stage
        setup_valid = 1'b1; req_dir_in = 1'b0; req_len = 16'd8;
        @(negedge clk);
        setup_valid = 1'b0;
        check("R4 OUT before reset", state_o, 3);
        rst_n = 1'b0;
        #1;
        check("R1 async reset state", state_o, 1);
        check("R1 async reset reply", rsp_rd_data, 0);
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule